// File: doc/BRIEF.md
# Nibble Shift and Rotate Execution Unit

This unit decodes and carries out the four single-bit shift and rotate instructions of a 4-bit processor core. Each of them moves one bit through the carry flag. Two of them are logical shifts that fill with zero. The other two are rotates that treat carry and the nibble as one 5-bit ring. The operand is register A, register B, or a nibble in data memory. The memory address comes from the 16-bit X or Y index register, and that index can be stepped by one after the access.

The surrounding core owns the registers and the flags. It presents their current values on the unit's inputs. It also pulses `start` with a 13-bit instruction word while the unit is not busy. The unit answers with write enables and new values. The core commits these at the next clock edge. A register form finishes in the cycle of `start`. A memory form reads in that cycle and writes back in the following cycle, while `busy` is high. The memory port is synchronous: read data appears in the cycle after the read strobe.

Top module: `nsr_unit`

## Requirements
- R1: Logical left shift: the result is the operand moved up one place with 0 entering bit 0, and carry out is the old bit 3.
- R2: Logical right shift: the result is the operand moved down one place with 0 entering bit 3, and carry out is the old bit 0.
- R3: Rotate left through carry: the old carry enters bit 0, and the old bit 3 becomes the new carry.
- R4: Rotate right through carry: the old carry enters bit 3, and the old bit 0 becomes the new carry.
- R5: A word with bits[12:5] = 1000_0111, bit 4 = 1 and bit 3 = 0 is a register form. In this form bits[1:0] give the operation (00 left shift, 01 right shift, 10 rotate left, 11 rotate right) and bit 2 picks A (0) or B (1). It completes in the `start` cycle and writes only the picked register, with `done` high.
- R6: A word with bits[12:5] = 1000_0111 and bit 4 = 0 is a memory form. In this form bits[3:2] give the operation with the same coding, and bits[1:0] pick the address: 00 X, 01 X then step, 10 Y, 11 Y then step. In the `start` cycle the unit raises `mem_rd` at the index value. In the next cycle it raises `mem_wr` and `done` at the same address, with the result as write data.
- R7: A stepping memory form writes index+1, wrapping modulo 2^16, to the chosen index register in the second cycle. A form that does not step writes no index.
- R8: Every completed instruction writes both flags. Z is 1 exactly when the 4-bit result is zero.
- R9: Any other word with `start` raises `illegal` for that cycle. It produces no register, index, flag or memory access.
- R10: While `busy` is high, `start` is ignored.
- R11: After reset the unit is idle: `busy`, `done`, `mem_rd`, `mem_wr` and `flag_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction present |
| instr | input | 13 | Instruction word |
| a_in | input | 4 | Current A register |
| b_in | input | 4 | Current B register |
| x_in | input | 16 | Current X index |
| y_in | input | 16 | Current Y index |
| c_in | input | 1 | Current carry flag |
| mem_rdata | input | 4 | Memory read data, one cycle after `mem_rd` |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 4 | Memory write data |
| res_nib | output | 4 | Result nibble for A or B |
| a_we | output | 1 | Write `res_nib` to A |
| b_we | output | 1 | Write `res_nib` to B |
| x_we | output | 1 | Write `idx_nxt` to X |
| y_we | output | 1 | Write `idx_nxt` to Y |
| idx_nxt | output | 16 | Stepped index value |
| flag_we | output | 1 | Write C and Z flags |
| c_out | output | 1 | New carry |
| z_out | output | 1 | New zero flag |
| busy | output | 1 | Second cycle of a memory form |
| done | output | 1 | Instruction completes this cycle |
| illegal | output | 1 | Unrecognised word |

## Verification
The register forms and illegal words give their answer in the same cycle as `start`. A memory form shows its read strobe in that cycle and its write, flag and index results exactly one cycle later. The driver raises `start` at a falling edge and checks the read phase 2 ns later. The scoreboard monitor samples 2 ns after every falling edge and pops one expected item for each cycle with `done` or `illegal` high. An early, late or extra completion therefore shows up as a mismatch or as a leftover item. After the run, the register and memory images that the bench commits from the write enables are compared with the bench's own model. This shows that nothing outside the addressed target changed.

// File: rtl/nsr_pkg.sv
package nsr_pkg;

   typedef enum logic [1:0] {
      OP_SHL = 2'b00,
      OP_SHR = 2'b01,
      OP_ROL = 2'b10,
      OP_ROR = 2'b11
   } shop_e;

   typedef struct packed {
      logic  legal;
      logic  is_mem;
      shop_e op;
      logic  sel_b;
      logic  use_y;
      logic  post_inc;
   } dec_t;

   localparam logic [7:0] GROUP_TAG = 8'b1000_0111;

endpackage

// File: rtl/nsr_decode.sv
module nsr_decode
   import nsr_pkg::*;
#(
   parameter int INSN_W = 13
) (
   input  logic [INSN_W-1:0] instr,
   output dec_t              dec
);

   localparam int TAG_LSB = INSN_W - 8;

   if (INSN_W != 13) begin : g_bad_width
      $error("nsr_decode: INSN_W must be 13");
   end

   logic tag_hit;
   assign tag_hit = (instr[INSN_W-1:TAG_LSB] == GROUP_TAG);

   always_comb begin
      dec = '0;
      if (instr[4]) begin
         dec.legal    = tag_hit & ~instr[3];
         dec.is_mem   = 1'b0;
         dec.op       = shop_e'(instr[1:0]);
         dec.sel_b    = instr[2];
      end else begin
         dec.legal    = tag_hit;
         dec.is_mem   = 1'b1;
         dec.op       = shop_e'(instr[3:2]);
         dec.use_y    = instr[1];
         dec.post_inc = instr[0];
      end
   end

endmodule

// File: rtl/nsr_shifter.sv
module nsr_shifter
   import nsr_pkg::*;
#(
   parameter int W = 4
) (
   input  shop_e        op,
   input  logic [W-1:0] din,
   input  logic         cin,
   output logic [W-1:0] dout,
   output logic         cout,
   output logic         zero
);

   if (W < 2) begin : g_bad_w
      $error("nsr_shifter: W must be at least 2");
   end

   logic fill;
   logic go_left;

   assign fill    = op[1] ? cin : 1'b0;
   assign go_left = ~op[0];

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic from_low;
      logic from_high;
      if (i == 0) begin : g_lo
         assign from_low = fill;
      end else begin : g_lo
         assign from_low = din[i-1];
      end
      if (i == W - 1) begin : g_hi
         assign from_high = fill;
      end else begin : g_hi
         assign from_high = din[i+1];
      end
      assign dout[i] = go_left ? from_low : from_high;
   end

   assign cout = go_left ? din[W-1] : din[0];
   assign zero = ~|dout;

endmodule

// File: rtl/nsr_seq.sv
module nsr_seq
   import nsr_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  shop_e         op_in,
   input  logic [AW-1:0] addr_in,
   input  logic          use_y_in,
   input  logic          inc_in,
   output logic          in_wr,
   output shop_e         op_q,
   output logic [AW-1:0] addr_q,
   output logic          use_y_q,
   output logic          inc_q
);

   typedef enum logic {ST_IDLE = 1'b0, ST_WR = 1'b1} st_e;

   st_e state;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         op_q    <= OP_SHL;
         addr_q  <= '0;
         use_y_q <= 1'b0;
         inc_q   <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (accept) begin
               state   <= ST_WR;
               op_q    <= op_in;
               addr_q  <= addr_in;
               use_y_q <= use_y_in;
               inc_q   <= inc_in;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign in_wr = (state == ST_WR);

endmodule

// File: rtl/nsr_unit.sv
module nsr_unit
   import nsr_pkg::*;
#(
   parameter int NIB_W  = 4,
   parameter int ADDR_W = 16,
   parameter int INSN_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [INSN_W-1:0] instr,
   input  logic [NIB_W-1:0]  a_in,
   input  logic [NIB_W-1:0]  b_in,
   input  logic [ADDR_W-1:0] x_in,
   input  logic [ADDR_W-1:0] y_in,
   input  logic              c_in,
   input  logic [NIB_W-1:0]  mem_rdata,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [NIB_W-1:0]  mem_wdata,
   output logic [NIB_W-1:0]  res_nib,
   output logic              a_we,
   output logic              b_we,
   output logic              x_we,
   output logic              y_we,
   output logic [ADDR_W-1:0] idx_nxt,
   output logic              flag_we,
   output logic              c_out,
   output logic              z_out,
   output logic              busy,
   output logic              done,
   output logic              illegal
);

   localparam logic [ADDR_W-1:0] IDX_STEP = ADDR_W'(1);

   if (ADDR_W < 2) begin : g_bad_aw
      $error("nsr_unit: ADDR_W must be at least 2");
   end

   dec_t              dec;
   logic              in_wr;
   shop_e             op_q;
   logic [ADDR_W-1:0] addr_q;
   logic              use_y_q;
   logic              inc_q;
   logic              idle_go;
   logic              acc_reg;
   logic              acc_mem;
   shop_e             sh_op;
   logic [NIB_W-1:0]  sh_in;
   logic [NIB_W-1:0]  sh_out;
   logic              sh_cout;
   logic              sh_zero;
   logic [ADDR_W-1:0] rd_addr;

   nsr_decode #(.INSN_W(INSN_W)) u_dec (
      .instr (instr),
      .dec   (dec)
   );

   assign idle_go = start & ~in_wr;
   assign acc_reg = idle_go & dec.legal & ~dec.is_mem;
   assign acc_mem = idle_go & dec.legal &  dec.is_mem;
   assign rd_addr = dec.use_y ? y_in : x_in;

   nsr_seq #(.AW(ADDR_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (acc_mem),
      .op_in    (dec.op),
      .addr_in  (rd_addr),
      .use_y_in (dec.use_y),
      .inc_in   (dec.post_inc),
      .in_wr    (in_wr),
      .op_q     (op_q),
      .addr_q   (addr_q),
      .use_y_q  (use_y_q),
      .inc_q    (inc_q)
   );

   always_comb begin
      if (in_wr) begin
         sh_op = op_q;
         sh_in = mem_rdata;
      end else begin
         sh_op = dec.op;
         sh_in = dec.sel_b ? b_in : a_in;
      end
   end

   nsr_shifter #(.W(NIB_W)) u_sh (
      .op   (sh_op),
      .din  (sh_in),
      .cin  (c_in),
      .dout (sh_out),
      .cout (sh_cout),
      .zero (sh_zero)
   );

   assign illegal   = idle_go & ~dec.legal;
   assign a_we      = acc_reg & ~dec.sel_b;
   assign b_we      = acc_reg &  dec.sel_b;
   assign mem_rd    = acc_mem;
   assign mem_wr    = in_wr;
   assign mem_addr  = in_wr ? addr_q : rd_addr;
   assign mem_wdata = sh_out;
   assign res_nib   = sh_out;
   assign c_out     = sh_cout;
   assign z_out     = sh_zero;
   assign flag_we   = acc_reg | in_wr;
   assign done      = acc_reg | in_wr;
   assign busy      = in_wr;
   assign x_we      = in_wr & inc_q & ~use_y_q;
   assign y_we      = in_wr & inc_q &  use_y_q;
   assign idx_nxt   = addr_q + IDX_STEP;

endmodule

// File: rtl/nsr_unit_chk.sv
module nsr_unit_chk #(
   parameter int W  = 4,
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          a_we,
   input logic          b_we,
   input logic          x_we,
   input logic          y_we,
   input logic          flag_we,
   input logic          mem_rd,
   input logic          mem_wr,
   input logic [AW-1:0] mem_addr,
   input logic [W-1:0]  res_nib,
   input logic          z_out,
   input logic [AW-1:0] idx_nxt,
   input logic          busy,
   input logic          done,
   input logic          illegal
);

   // R9
   illegal_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !(a_we || b_we || x_we || y_we || flag_we || mem_rd || mem_wr));

   // R6
   rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> (mem_wr && done));

   // R6
   wr_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (mem_addr == $past(mem_addr)));

   // R7
   inc_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (x_we || y_we) |-> (idx_nxt == AW'($past(mem_addr) + 1'b1)));

   // R8
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |-> (z_out == (res_nib == '0)));

   // R5
   one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({a_we, b_we, mem_wr}));

   // R10
   busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

endmodule

bind nsr_unit nsr_unit_chk #(.W(NIB_W), .AW(ADDR_W)) u_chk (.*);

// File: tb/nsr_unit_test.sv
module nsr_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [12:0] instr = '0;
   logic [3:0]  hA = '0, hB = '0;
   logic [15:0] hX = '0, hY = '0;
   logic        hC = 1'b0;
   logic [3:0]  hmem [256];
   logic [3:0]  rdq = '0;

   logic        mem_rd, mem_wr, a_we, b_we, x_we, y_we, flag_we;
   logic        c_out, z_out, busy, done, illegal;
   logic [15:0] mem_addr, idx_nxt;
   logic [3:0]  mem_wdata, res_nib;

   logic [3:0]  mA, mB;
   logic [15:0] mX, mY;
   logic        mC;
   logic [3:0]  mmem [256];

   int total = 0;
   int bad = 0;
   bit finished = 0;

   typedef struct {
      int          kind;
      logic [3:0]  res;
      logic        c;
      logic        z;
      logic        wa, wb, wx, wy;
      logic [15:0] idx;
      logic [15:0] addr;
      string       req;
   } item_t;

   item_t sbq[$];

   localparam logic [12:0] BASE = 13'h10E0;

   always #4 clk = ~clk;

   nsr_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
      .a_in(hA), .b_in(hB), .x_in(hX), .y_in(hY), .c_in(hC),
      .mem_rdata(rdq), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .res_nib(res_nib),
      .a_we(a_we), .b_we(b_we), .x_we(x_we), .y_we(y_we),
      .idx_nxt(idx_nxt), .flag_we(flag_we), .c_out(c_out), .z_out(z_out),
      .busy(busy), .done(done), .illegal(illegal)
   );

   // host registers and memory commit the unit's results
   always @(posedge clk) begin
      if (a_we)    hA <= res_nib;
      if (b_we)    hB <= res_nib;
      if (flag_we) hC <= c_out;
      if (x_we)    hX <= idx_nxt;
      if (y_we)    hY <= idx_nxt;
      if (mem_wr)  hmem[mem_addr[7:0]] <= mem_wdata;
      if (mem_rd)  rdq <= hmem[mem_addr[7:0]];
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic ref_op(input logic [1:0] op, input logic [3:0] d, input logic ci,
                         output logic [3:0] r, output logic co);
      case (op)
         2'b00: begin r = {d[2:0], 1'b0}; co = d[3]; end
         2'b01: begin r = {1'b0, d[3:1]}; co = d[0]; end
         2'b10: begin r = {d[2:0], ci};   co = d[3]; end
         default: begin r = {ci, d[3:1]}; co = d[0]; end
      endcase
   endtask

   task automatic set_state(input logic [3:0] a, input logic [3:0] b,
                            input logic [15:0] x, input logic [15:0] y, input logic c);
      mA = a; mB = b; mX = x; mY = y; mC = c;
      hA = a; hB = b; hX = x; hY = y; hC = c;
   endtask

   task automatic poke(input logic [7:0] ad, input logic [3:0] v);
      mmem[ad] = v;
      hmem[ad] = v;
   endtask

   task automatic run(input logic [12:0] w, input bit hold, input logic [12:0] w2,
                      input string req);
      item_t it;
      logic [3:0] d, r;
      logic co;
      bit is_mem;
      it = '{kind: 0, res: '0, c: 1'b0, z: 1'b0, wa: 1'b0, wb: 1'b0,
             wx: 1'b0, wy: 1'b0, idx: '0, addr: '0, req: req};
      is_mem = 0;
      if (w[12:5] != 8'b1000_0111 || (w[4] && w[3])) begin
         it.kind = 2;
      end else if (w[4]) begin
         d = w[2] ? mB : mA;
         ref_op(w[1:0], d, mC, r, co);
         it.res = r; it.c = co; it.z = (r == 4'd0);
         it.wa = ~w[2]; it.wb = w[2];
         if (w[2]) mB = r; else mA = r;
         mC = co;
      end else begin
         is_mem = 1;
         it.kind = 1;
         it.addr = w[1] ? mY : mX;
         d = mmem[it.addr[7:0]];
         ref_op(w[3:2], d, mC, r, co);
         it.res = r; it.c = co; it.z = (r == 4'd0);
         mmem[it.addr[7:0]] = r;
         mC = co;
         it.idx = it.addr + 16'd1;
         if (w[0]) begin
            if (w[1]) begin it.wy = 1; mY = it.idx; end
            else      begin it.wx = 1; mX = it.idx; end
         end
      end
      sbq.push_back(it);
      start = 1'b1;
      instr = w;
      if (is_mem) begin
         #2;
         chk(mem_rd === 1'b1 && mem_addr === it.addr && busy === 1'b0, "R6",
             "read phase addr", {15'd0, mem_rd, mem_addr}, {16'd1, it.addr});
         @(negedge clk);
         start = hold;
         instr = w2;
         #2;
         chk(busy === 1'b1 && mem_rd === 1'b0 && illegal === 1'b0, "R10",
             "busy cycle", {busy, mem_rd, illegal}, 3'b100);
         @(negedge clk);
      end else begin
         @(negedge clk);
      end
      start = 1'b0;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      item_t e;
      #2;
      if (rst_n && (done === 1'b1 || illegal === 1'b1)) begin
         if (sbq.size() == 0) begin
            chk(0, "R10", "unexpected completion", {done, illegal}, 0);
         end else begin
            e = sbq.pop_front();
            if (e.kind == 2) begin
               chk(illegal === 1'b1 && done === 1'b0, e.req, "illegal flag",
                   {illegal, done}, 2'b10);
               chk({a_we, b_we, x_we, y_we, flag_we, mem_rd, mem_wr} === 7'd0, e.req,
                   "no effect", {a_we, b_we, x_we, y_we, flag_we, mem_rd, mem_wr}, 0);
            end else begin
               chk(done === 1'b1 && illegal === 1'b0 && flag_we === 1'b1, "R8",
                   "done and flag write", {done, illegal, flag_we}, 3'b101);
               chk(res_nib === e.res && c_out === e.c, e.req, "result and carry",
                   {c_out, res_nib}, {e.c, e.res});
               chk(z_out === e.z, "R8", "zero flag", z_out, e.z);
               if (e.kind == 0) begin
                  chk({a_we, b_we, mem_wr, x_we, y_we} === {e.wa, e.wb, 3'b000}, "R5",
                      "register targets", {a_we, b_we, mem_wr, x_we, y_we},
                      {e.wa, e.wb, 3'b000});
               end else begin
                  chk(mem_wr === 1'b1 && mem_addr === e.addr && mem_wdata === e.res,
                      "R6", "write back", {mem_wr, mem_addr, mem_wdata},
                      {1'b1, e.addr, e.res});
                  chk({x_we, y_we, a_we, b_we} === {e.wx, e.wy, 2'b00}, "R7",
                      "index write enables", {x_we, y_we, a_we, b_we}, {e.wx, e.wy, 2'b00});
                  if (e.wx || e.wy)
                     chk(idx_nxt === e.idx, "R7", "stepped index", idx_nxt, e.idx);
               end
            end
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         chk(0, "watchdog", "run did not finish", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         hmem[i] = 4'(i);
         mmem[i] = 4'(i);
      end
      set_state(4'b1001, 4'b0110, 16'h0010, 16'hFFFF, 1'b0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2;
      // R11 reset state
      chk({busy, done, mem_rd, mem_wr, flag_we} === 5'd0, "R11", "idle after reset",
          {busy, done, mem_rd, mem_wr, flag_we}, 0);
      @(negedge clk);

      run(BASE | 13'h10, 0, '0, "R1");          // shift left A
      run(BASE | 13'h15, 0, '0, "R2");          // shift right B
      set_state(4'b0010, 4'b0011, 16'h0010, 16'hFFFF, 1'b1);
      run(BASE | 13'h12, 0, '0, "R3");          // rotate left A, carry in 1
      run(BASE | 13'h17, 0, '0, "R4");          // rotate right B
      set_state(4'b0001, 4'b1000, 16'h0010, 16'hFFFF, 1'b1);
      run(BASE | 13'h11, 0, '0, "R8");          // 0001 >> 1 gives zero
      run(BASE | 13'h14, 0, '0, "R8");          // 1000 << 1 gives zero

      poke(8'h10, 4'b1010); poke(8'h11, 4'b0011);
      poke(8'hFF, 4'b1000); poke(8'h00, 4'b0001);
      run(BASE | 13'h00, 0, '0, "R1");          // shift left [X]
      run(BASE | 13'h05, 0, '0, "R7");          // shift right [X], step X
      run(BASE | 13'h09, 0, '0, "R3");          // rotate left [X], step X
      run(BASE | 13'h0A, 0, '0, "R6");          // rotate left [Y]
      run(BASE | 13'h0F, 1, BASE | 13'h10, "R7"); // rotate right [Y], step wraps; start while busy
      run(BASE | 13'h0E, 0, '0, "R4");          // rotate right [Y] at wrapped index

      run(BASE | 13'h18, 0, '0, "R9");          // register form with bit 3 set
      run(13'h00E0, 0, '0, "R9");
      run(13'h1FFF, 0, '0, "R9");

      for (int op = 0; op < 4; op++) begin
         for (int v = 0; v < 16; v++) begin
            set_state(4'(v), 4'(15 - v), mX, mY, v[1]);
            run(BASE | 13'h10 | 13'(op), 0, '0, "R5");
            run(BASE | 13'h14 | 13'(op), 0, '0, "R5");
         end
      end

      @(negedge clk);
      #2;
      chk(sbq.size() == 0, "R10", "scoreboard drained", sbq.size(), 0);
      // targets not addressed keep their values
      chk(hA === mA && hB === mB && hC === mC, "R5", "registers vs model",
          {hC, hA, hB}, {mC, mA, mB});
      chk(hX === mX && hY === mY, "R7", "indexes vs model", {hX, hY}, {mX, mY});
      for (int i = 0; i < 256; i++) begin
         if (hmem[i] !== mmem[i])
            chk(0, "R6", "memory vs model", hmem[i], mmem[i]);
      end
      chk(hmem[8'h10] === mmem[8'h10] && hmem[8'h00] === mmem[8'h00], "R6",
          "written nibbles", {hmem[8'h10], hmem[8'h00]}, {mmem[8'h10], mmem[8'h00]});
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule